// File: doc/BRIEF.md
# Serial NAND Page Sequencer

This block runs whole-page operations on a serial NAND flash device. A host hands it one request at a time: a page read, a page program or a block erase, each with a 24-bit row (page) address. The sequencer breaks the request into the chain of device commands the flash needs and passes them one by one to a lower serial transaction engine, which handles the wire timing. After any command that starts an internal array operation, the sequencer polls the device status byte until the device reports idle. It then checks the fail bit for that kind of operation and ends the request with a single done pulse and a 2-bit result code.

Page data does not pass through the host port. During the cache read, bytes coming back from the engine are written into a local page buffer at their index within the page. During the program load, the engine takes bytes, and the sequencer supplies each one from the same buffer by index. A write-enable input gates program and erase. A per-request poll limit stops a device that stays busy forever from hanging the sequencer.

Top module: `nand_page_seq`

## Requirements
- R1: `req_ready_o` is high exactly when no request is in progress, and a request is accepted on a cycle where both `req_valid_i` and `req_ready_o` are high. Every accepted request ends with `done_o` high for one cycle, with `result_o` valid in that cycle. Result codes: 0 ok, 1 device fail, 2 write-protected, 3 engine error. Operation codes on `req_op_i`: 0 read, 1 program, 2 erase.
- R2: A read issues 0x13 with the row address (3 address bytes, no data), then polls status. It then issues a cache read with 2 column-address bytes of value zero, 8 dummy clocks and a page-length read. The cache read uses opcode 0x6B with `cmd_quad_o` high when quad is selected, and 0x0B with `cmd_quad_o` low otherwise.
- R3: A program issues 0x06 (no address, no data), then a program load, then 0x10 with the row (3 address bytes), then polls status. The program load has 2 column-address bytes of value zero and a page-length write. It uses opcode 0x32 with quad, or 0x02 without.
- R4: An erase issues 0x06, then 0xD8 with the row address (3 address bytes) whose low log2(pages per block) bits are forced to zero, then polls status.
- R5: A status poll is opcode 0x0F with address 0xC0 (1 address byte) and a 1-byte read. It is issued again for as long as the returned status has bit 0 set.
- R6: Once the device reports idle, a program fails (code 1) if status bit 3 is set, and an erase fails (code 1) if status bit 2 is set. A read ignores both bits. Otherwise the result is 0.
- R7: While `wr_en_i` is low at acceptance, a program or an erase issues no command and ends with code 2, with `done_o` in the cycle after acceptance. A read goes ahead normally.
- R8: If the device is still busy on the L-th status reading of one request, where L is `poll_limit_i` at acceptance (L of 0 counts as 1), the request ends with code 3 and issues no further command.
- R9: If the engine reports an error on completing any command, the request ends with code 3 and issues no further command.
- R10: Operation code 3 is refused with result 3, and no command is issued.
- R11: During a cache read, each byte the engine presents is written into the buffer at an address equal to its index within the page, counted from zero.
- R12: During a program load, each byte the engine takes is the buffer byte at its index within the page, counted from zero.
- R13: While a command is offered and not yet accepted by the engine, all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be accepted |
| req_op_i | input | 2 | Operation: 0 read, 1 program, 2 erase |
| req_row_i | input | ROW_W | Row (page) address |
| wr_en_i | input | 1 | Program and erase allowed |
| quad_i | input | 1 | Use four-lane data transfers |
| poll_limit_i | input | POLL_W | Maximum busy status readings |
| done_o | output | 1 | One-cycle end-of-request pulse |
| result_o | output | 2 | Result code, valid with done_o |
| cmd_valid_o | output | 1 | Command offered to engine |
| cmd_ready_i | input | 1 | Engine accepts command |
| cmd_opcode_o | output | 8 | Command opcode |
| cmd_addr_o | output | ROW_W | Address value |
| cmd_addr_len_o | output | 2 | Number of address bytes |
| cmd_dummy_o | output | 4 | Dummy clocks after address |
| cmd_dir_o | output | 2 | Data phase: 0 none, 1 read, 2 write |
| cmd_len_o | output | LEN_W | Data byte count |
| cmd_quad_o | output | 1 | Data phase uses four lanes |
| eng_done_i | input | 1 | Engine finished current command |
| eng_err_i | input | 1 | Engine error, valid with eng_done_i |
| eng_status_i | input | 8 | Byte read by a status poll, valid with eng_done_i |
| eng_rx_valid_i | input | 1 | Read byte from device valid |
| eng_rx_data_i | input | 8 | Read byte from device |
| eng_tx_take_i | input | 1 | Engine consumes a write byte |
| eng_tx_data_o | output | 8 | Write byte to device |
| buf_addr_o | output | COL_W | Page buffer byte address |
| buf_we_o | output | 1 | Page buffer write strobe |
| buf_wdata_o | output | 8 | Page buffer write data |
| buf_rdata_i | input | 8 | Page buffer read data at buf_addr_o |

## Verification
The bench scripts the status bytes the device returns and injects engine errors. Its reference model predicts the exact command list and result for each request. Polls are tried on status values with only the wrong fail bit set. A design that tested one shared fail bit would report a program failure on an erase-fail bit, or fail a read that should pass. The bench also checks the poll limit at the exact boundary: an off-by-one counter would issue one status command too many or too few, and the command-queue comparison reports the extra or missing poll. It refuses protected requests and the reserved operation code with no commands and a done pulse one cycle later. It checks erase alignment with a row whose low bits are all set, and checks every byte position of full-page reads and program loads, which catches a pointer that is not cleared or that advances on the wrong strobe.

// File: rtl/nand_seq_pkg.sv
// Shared types and device opcodes for the serial NAND page sequencer.
// Assumes a device that uses a one-byte opcode and a one-byte status register.
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_DEVFAIL = 2'd1,
        RES_WPROT   = 2'd2,
        RES_ENGERR  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        STP_WREN,
        STP_ARRAY_RD,
        STP_PLOAD,
        STP_PEXEC,
        STP_BERASE,
        STP_POLL,
        STP_CACHE_RD
    } step_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2
    } dir_e;

    localparam logic [7:0] OPC_WREN      = 8'h06;
    localparam logic [7:0] OPC_ARRAY_RD  = 8'h13;
    localparam logic [7:0] OPC_CACHE_RD1 = 8'h0B;
    localparam logic [7:0] OPC_CACHE_RD4 = 8'h6B;
    localparam logic [7:0] OPC_PLOAD1    = 8'h02;
    localparam logic [7:0] OPC_PLOAD4    = 8'h32;
    localparam logic [7:0] OPC_PEXEC     = 8'h10;
    localparam logic [7:0] OPC_BERASE    = 8'hD8;
    localparam logic [7:0] OPC_GETFEAT   = 8'h0F;
    localparam logic [7:0] STATUS_REG    = 8'hC0;

    localparam int ST_BUSY_BIT  = 0;
    localparam int ST_EFAIL_BIT = 2;
    localparam int ST_PFAIL_BIT = 3;

endpackage

// File: rtl/nand_cmd_decode.sv
// Command field decoder: turns the current step of a flow into the
// opcode, address, dummy and data fields handed to the serial engine.
// Assumes purely combinational use; the caller holds step and row stable.
module nand_cmd_decode
    import nand_seq_pkg::*;
#(
    parameter int ROW_W      = 24,
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int BLK_SHIFT  = 6
) (
    input  step_e              step_i,
    input  logic               quad_i,
    input  logic [ROW_W-1:0]   row_i,
    output logic [7:0]         opcode_o,
    output logic [ROW_W-1:0]   addr_o,
    output logic [1:0]         addr_len_o,
    output logic [3:0]         dummy_o,
    output logic [1:0]         dir_o,
    output logic [LEN_W-1:0]   len_o,
    output logic               quad_o
);

    logic [ROW_W-1:0] blk_row;

    // Block-aligned row for erase: low page-in-block bits cleared.
    always_comb begin
        blk_row = row_i;
        blk_row[BLK_SHIFT-1:0] = '0;
    end

    // Field table for each step.
    always_comb begin
        opcode_o   = OPC_WREN;
        addr_o     = '0;
        addr_len_o = 2'd0;
        dummy_o    = 4'd0;
        dir_o      = DIR_NONE;
        len_o      = '0;
        quad_o     = 1'b0;
        case (step_i)
            STP_WREN: opcode_o = OPC_WREN;
            STP_ARRAY_RD: begin
                opcode_o   = OPC_ARRAY_RD;
                addr_o     = row_i;
                addr_len_o = 2'd3;
            end
            STP_PLOAD: begin
                opcode_o   = quad_i ? OPC_PLOAD4 : OPC_PLOAD1;
                addr_len_o = 2'd2;
                dir_o      = DIR_WR;
                len_o      = LEN_W'(PAGE_BYTES);
                quad_o     = quad_i;
            end
            STP_PEXEC: begin
                opcode_o   = OPC_PEXEC;
                addr_o     = row_i;
                addr_len_o = 2'd3;
            end
            STP_BERASE: begin
                opcode_o   = OPC_BERASE;
                addr_o     = blk_row;
                addr_len_o = 2'd3;
            end
            STP_POLL: begin
                opcode_o   = OPC_GETFEAT;
                addr_o     = ROW_W'(STATUS_REG);
                addr_len_o = 2'd1;
                dir_o      = DIR_RD;
                len_o      = LEN_W'(1);
            end
            STP_CACHE_RD: begin
                opcode_o   = quad_i ? OPC_CACHE_RD4 : OPC_CACHE_RD1;
                addr_len_o = 2'd2;
                dummy_o    = 4'd8;
                dir_o      = DIR_RD;
                len_o      = LEN_W'(PAGE_BYTES);
                quad_o     = quad_i;
            end
            default: opcode_o = OPC_WREN;
        endcase
    end

endmodule

// File: rtl/nand_poll_timer.sv
// Busy-reading counter for status polling. Counts status readings that
// come back busy and flags the reading that reaches the limit.
// Assumes a limit of zero is treated like a limit of one.
module nand_poll_timer #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              busy_i,
    input  logic [POLL_W-1:0] limit_i,
    output logic              expired_o
);

    logic [POLL_W-1:0] cnt_q;

    // Current busy reading reaches the limit.
    always_comb begin
        expired_o = busy_i &&
            (({1'b0, cnt_q} + (POLL_W+1)'(1)) >= {1'b0, limit_i});
    end

    // Count busy readings since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (busy_i)
            cnt_q <= cnt_q + POLL_W'(1);
    end

endmodule

// File: rtl/nand_byte_ptr.sv
// Byte index within a page for the buffer side of a data transfer.
// Assumes clear is raised before each transfer command starts.
module nand_byte_ptr #(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [COL_W-1:0] ptr_o
);

    // Reset to zero on clear, step by one per moved byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_o <= '0;
        else if (clear_i)
            ptr_o <= '0;
        else if (adv_i)
            ptr_o <= ptr_o + COL_W'(1);
    end

endmodule

// File: rtl/nand_page_seq.sv
// Serial NAND page sequencer top. Accepts one page read, page program or
// block erase at a time. Issues the device command chain to the serial
// engine and polls status until the device is idle, then reports a
// result code. Assumes the engine takes one command at a time and raises
// eng_done_i once per accepted command.
module nand_page_seq
    import nand_seq_pkg::*;
#(
    parameter int ROW_W           = 24,
    parameter int POLL_W          = 16,
    parameter int PAGE_BYTES      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    localparam int COL_W          = $clog2(PAGE_BYTES),
    localparam int LEN_W          = COL_W + 1,
    localparam int BLK_SHIFT      = $clog2(PAGES_PER_BLOCK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        req_op_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic              wr_en_i,
    input  logic              quad_i,
    input  logic [POLL_W-1:0] poll_limit_i,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [7:0]        cmd_opcode_o,
    output logic [ROW_W-1:0]  cmd_addr_o,
    output logic [1:0]        cmd_addr_len_o,
    output logic [3:0]        cmd_dummy_o,
    output logic [1:0]        cmd_dir_o,
    output logic [LEN_W-1:0]  cmd_len_o,
    output logic              cmd_quad_o,
    input  logic              eng_done_i,
    input  logic              eng_err_i,
    input  logic [7:0]        eng_status_i,
    input  logic              eng_rx_valid_i,
    input  logic [7:0]        eng_rx_data_i,
    input  logic              eng_tx_take_i,
    output logic [7:0]        eng_tx_data_o,
    output logic [COL_W-1:0]  buf_addr_o,
    output logic              buf_we_o,
    output logic [7:0]        buf_wdata_o,
    input  logic [7:0]        buf_rdata_i
);

    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_e;

    sq_e               state_q;
    step_e             step_q;
    op_e               op_q;
    logic [ROW_W-1:0]  row_q;
    logic              quad_q;
    logic [POLL_W-1:0] lim_q;
    res_e              res_q;

    logic accept;
    logic step_end;
    logic poll_busy;
    logic poll_tick;
    logic poll_expired;
    logic fail_bit;
    logic refuse_wp;
    logic in_rd_xfer;
    logic in_wr_xfer;

    // Handshake and per-reading qualifiers.
    always_comb begin
        req_ready_o = (state_q == SQ_IDLE);
        accept      = req_ready_o && req_valid_i;
        refuse_wp   = !wr_en_i && (req_op_i == OP_PROG || req_op_i == OP_ERASE);
        step_end    = (state_q == SQ_WAIT) && eng_done_i;
        poll_busy   = eng_status_i[ST_BUSY_BIT];
        poll_tick   = step_end && !eng_err_i && (step_q == STP_POLL) && poll_busy;
        in_rd_xfer  = (state_q == SQ_WAIT) && (step_q == STP_CACHE_RD);
        in_wr_xfer  = (state_q == SQ_WAIT) && (step_q == STP_PLOAD);
    end

    // Fail bit that applies to the running operation.
    always_comb begin
        case (op_q)
            OP_PROG:  fail_bit = eng_status_i[ST_PFAIL_BIT];
            OP_ERASE: fail_bit = eng_status_i[ST_EFAIL_BIT];
            default:  fail_bit = 1'b0;
        endcase
    end

    // Flow controller: accept, issue, wait, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            step_q  <= STP_WREN;
            op_q    <= OP_READ;
            row_q   <= '0;
            quad_q  <= 1'b0;
            lim_q   <= '0;
            res_q   <= RES_OK;
        end else begin
            case (state_q)
                SQ_IDLE: if (accept) begin
                    op_q   <= op_e'(req_op_i);
                    row_q  <= req_row_i;
                    quad_q <= quad_i;
                    lim_q  <= poll_limit_i;
                    res_q  <= RES_OK;
                    if (op_e'(req_op_i) == OP_RSVD) begin
                        res_q   <= RES_ENGERR;
                        state_q <= SQ_DONE;
                    end else if (refuse_wp) begin
                        res_q   <= RES_WPROT;
                        state_q <= SQ_DONE;
                    end else begin
                        step_q  <= (op_e'(req_op_i) == OP_READ) ? STP_ARRAY_RD : STP_WREN;
                        state_q <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: if (cmd_ready_i) state_q <= SQ_WAIT;
                SQ_WAIT: if (eng_done_i) begin
                    if (eng_err_i) begin
                        res_q   <= RES_ENGERR;
                        state_q <= SQ_DONE;
                    end else begin
                        state_q <= SQ_ISSUE;
                        case (step_q)
                            STP_WREN:     step_q <= (op_q == OP_PROG) ? STP_PLOAD : STP_BERASE;
                            STP_ARRAY_RD: step_q <= STP_POLL;
                            STP_PLOAD:    step_q <= STP_PEXEC;
                            STP_PEXEC:    step_q <= STP_POLL;
                            STP_BERASE:   step_q <= STP_POLL;
                            STP_POLL: begin
                                if (poll_busy) begin
                                    if (poll_expired) begin
                                        res_q   <= RES_ENGERR;
                                        state_q <= SQ_DONE;
                                    end
                                end else if (op_q == OP_READ) begin
                                    step_q <= STP_CACHE_RD;
                                end else begin
                                    res_q   <= fail_bit ? RES_DEVFAIL : RES_OK;
                                    state_q <= SQ_DONE;
                                end
                            end
                            default: begin
                                res_q   <= RES_OK;
                                state_q <= SQ_DONE;
                            end
                        endcase
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Request completion outputs.
    always_comb begin
        done_o      = (state_q == SQ_DONE);
        result_o    = res_q;
        cmd_valid_o = (state_q == SQ_ISSUE);
    end

    nand_cmd_decode #(
        .ROW_W      (ROW_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BLK_SHIFT  (BLK_SHIFT)
    ) decode_i (
        .step_i     (step_q),
        .quad_i     (quad_q),
        .row_i      (row_q),
        .opcode_o   (cmd_opcode_o),
        .addr_o     (cmd_addr_o),
        .addr_len_o (cmd_addr_len_o),
        .dummy_o    (cmd_dummy_o),
        .dir_o      (cmd_dir_o),
        .len_o      (cmd_len_o),
        .quad_o     (cmd_quad_o)
    );

    nand_poll_timer #(
        .POLL_W (POLL_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .busy_i    (poll_tick),
        .limit_i   (lim_q),
        .expired_o (poll_expired)
    );

    nand_byte_ptr #(
        .COL_W (COL_W)
    ) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == SQ_ISSUE),
        .adv_i   ((in_rd_xfer && eng_rx_valid_i) || (in_wr_xfer && eng_tx_take_i)),
        .ptr_o   (buf_addr_o)
    );

    // Page buffer data paths.
    always_comb begin
        buf_we_o      = in_rd_xfer && eng_rx_valid_i;
        buf_wdata_o   = eng_rx_data_i;
        eng_tx_data_o = buf_rdata_i;
    end

endmodule

// File: rtl/nand_page_seq_chk.sv
// Assertion checker for the page sequencer, attached by bind.
// Assumes the same parameter values as the instance it is bound to.
module nand_page_seq_chk #(
    parameter int ROW_W           = 24,
    parameter int LEN_W           = 12,
    parameter int PAGES_PER_BLOCK = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready_o,
    input logic             done_o,
    input logic             cmd_valid_o,
    input logic             cmd_ready_i,
    input logic [7:0]       cmd_opcode_o,
    input logic [ROW_W-1:0] cmd_addr_o,
    input logic [1:0]       cmd_addr_len_o,
    input logic [1:0]       cmd_dir_o,
    input logic [LEN_W-1:0] cmd_len_o,
    input logic             buf_we_o
);

    // R13
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_opcode_o)
            && $stable(cmd_addr_o) && $stable(cmd_len_o));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !cmd_valid_o && !done_o);

    // R5
    poll_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_opcode_o == 8'h0F |-> cmd_addr_o == ROW_W'(8'hC0)
            && cmd_addr_len_o == 2'd1 && cmd_dir_o == 2'd1 && cmd_len_o == LEN_W'(1));

    // R4
    erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_opcode_o == 8'hD8 |->
            (cmd_addr_o & ROW_W'(PAGES_PER_BLOCK - 1)) == '0);

    // R11
    buf_we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> !cmd_valid_o && !req_ready_o);

endmodule

bind nand_page_seq nand_page_seq_chk #(
    .ROW_W           (ROW_W),
    .LEN_W           (LEN_W),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready_o    (req_ready_o),
    .done_o         (done_o),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_ready_i    (cmd_ready_i),
    .cmd_opcode_o   (cmd_opcode_o),
    .cmd_addr_o     (cmd_addr_o),
    .cmd_addr_len_o (cmd_addr_len_o),
    .cmd_dir_o      (cmd_dir_o),
    .cmd_len_o      (cmd_len_o),
    .buf_we_o       (buf_we_o)
);

// File: tb/nand_page_seq_tb_top.sv
// Bench for the page sequencer: behavioural engine and device model, and a
// reference model that predicts the command list and result of each request.
module nand_page_seq_tb_top;

    localparam int PAGE  = 2048;
    localparam int COL_W = 11;
    localparam int LEN_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = '0;
    logic [23:0]      req_row = '0;
    logic             wr_en = 1'b0;
    logic             quad = 1'b0;
    logic [15:0]      poll_limit = '0;
    logic             done;
    logic [1:0]       result;
    logic             cmd_valid;
    logic             cmd_ready = 1'b0;
    logic [7:0]       cmd_opcode;
    logic [23:0]      cmd_addr;
    logic [1:0]       cmd_addr_len;
    logic [3:0]       cmd_dummy;
    logic [1:0]       cmd_dir;
    logic [LEN_W-1:0] cmd_len;
    logic             cmd_quad;
    logic             eng_done = 1'b0;
    logic             eng_err = 1'b0;
    logic [7:0]       eng_status = '0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_data = '0;
    logic             tx_take = 1'b0;
    logic [7:0]       tx_data;
    logic [COL_W-1:0] buf_addr;
    logic             buf_we;
    logic [7:0]       buf_wdata;
    logic [7:0]       buf_rdata;
    logic [7:0]       txmem [PAGE];

    assign buf_rdata = txmem[buf_addr];

    nand_page_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_op_i(req_op), .req_row_i(req_row), .wr_en_i(wr_en), .quad_i(quad),
        .poll_limit_i(poll_limit), .done_o(done), .result_o(result),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_opcode_o(cmd_opcode),
        .cmd_addr_o(cmd_addr), .cmd_addr_len_o(cmd_addr_len), .cmd_dummy_o(cmd_dummy),
        .cmd_dir_o(cmd_dir), .cmd_len_o(cmd_len), .cmd_quad_o(cmd_quad),
        .eng_done_i(eng_done), .eng_err_i(eng_err), .eng_status_i(eng_status),
        .eng_rx_valid_i(rx_valid), .eng_rx_data_i(rx_data), .eng_tx_take_i(tx_take),
        .eng_tx_data_o(tx_data), .buf_addr_o(buf_addr), .buf_we_o(buf_we),
        .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [52:0] exp_q[$];
    int st_q[$];
    int err_opc = -1;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [52:0] pack(input int opc, input int addr, input int alen,
                                         input int dmy, input int dir, input int len,
                                         input bit q);
        return {8'(opc), 24'(addr), 2'(alen), 4'(dmy), 2'(dir), 12'(len), q};
    endfunction

    // Push one expected command; report whether the engine will fail it.
    function automatic bit add(input int opc, input int addr, input int alen,
                               input int dmy, input int dir, input int len, input bit q);
        exp_q.push_back(pack(opc, addr, alen, dmy, dir, len, q));
        return (opc == err_opc);
    endfunction

    // Reference model: expected command list and result code.
    task automatic plan(input int op, input int row, input bit wren, input bit qd,
                        input int limit, output int res);
        int k, cnt, s, lim;
        res = 0;
        s = 0;
        if (op == 3) begin res = 3; return; end
        if (op != 0 && !wren) begin res = 2; return; end
        lim = (limit < 1) ? 1 : limit;
        if (op == 0) begin
            if (add('h13, row, 3, 0, 0, 0, 0)) begin res = 3; return; end
        end else begin
            if (add('h06, 0, 0, 0, 0, 0, 0)) begin res = 3; return; end
            if (op == 1) begin
                if (add(qd ? 'h32 : 'h02, 0, 2, 0, 2, PAGE, qd)) begin res = 3; return; end
                if (add('h10, row, 3, 0, 0, 0, 0)) begin res = 3; return; end
            end else begin
                if (add('hD8, row & ~63, 3, 0, 0, 0, 0)) begin res = 3; return; end
            end
        end
        cnt = 0;
        k = 0;
        forever begin
            s = (k < st_q.size()) ? st_q[k] : 0;
            k++;
            if (add('h0F, 'hC0, 1, 0, 1, 1, 0)) begin res = 3; return; end
            if ((s & 1) != 0) begin
                cnt++;
                if (cnt >= lim) begin res = 3; return; end
            end else break;
        end
        if (op == 0) begin
            if (add(qd ? 'h6B : 'h0B, 0, 2, 8, 1, PAGE, qd)) res = 3;
        end else if (op == 1) res = ((s & 8) != 0) ? 1 : 0;
        else res = ((s & 4) != 0) ? 1 : 0;
    endtask

    // Engine and device model: compares each offered command, moves data.
    initial begin
        logic [52:0] got, e;
        int opc, dir, len, bad;
        logic [7:0] st;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                got = {cmd_opcode, cmd_addr, cmd_addr_len, cmd_dummy, cmd_dir, cmd_len, cmd_quad};
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected command", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, "R2/R3/R4/R5", "command fields", got, e);
                end
                opc = int'(cmd_opcode);
                dir = int'(cmd_dir);
                len = int'(cmd_len);
                st = '0;
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                if (opc == 'h0F) st = (st_q.size() > 0) ? 8'(st_q.pop_front()) : 8'h00;
                bad = 0;
                if (dir == 1 && len > 1) begin
                    for (int i = 0; i < len; i++) begin
                        rx_valid = 1'b1;
                        rx_data = 8'(i * 3) ^ 8'hA7;
                        #1;
                        if (!buf_we || buf_addr != COL_W'(i) || buf_wdata != rx_data) bad++;
                        @(negedge clk);
                    end
                    rx_valid = 1'b0;
                    chk(bad == 0, "R11", "cache read buffer writes", bad, 0);
                end
                if (dir == 2) begin
                    for (int i = 0; i < len; i++) begin
                        tx_take = 1'b1;
                        #1;
                        if (tx_data != (8'(i) ^ 8'h5A)) bad++;
                        @(negedge clk);
                    end
                    tx_take = 1'b0;
                    chk(bad == 0, "R12", "program load bytes", bad, 0);
                end
                eng_done = 1'b1;
                eng_err = (opc == err_opc);
                eng_status = st;
                @(negedge clk);
                eng_done = 1'b0;
                eng_err = 1'b0;
            end
        end
    end

    // One request from the host side, checked every cycle until done.
    task automatic run(input string name, input int op, input int row, input bit wren,
                       input bit qd, input int limit, input string req);
        int res, cyc, bad;
        plan(op, row, wren, qd, limit, res);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", {name, " ready before request"}, req_ready, 1);
        req_op = 2'(op);
        req_row = 24'(row);
        wr_en = wren;
        quad = qd;
        poll_limit = 16'(limit);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        bad = 0;
        forever begin
            cyc++;
            if (req_ready) bad++;
            if (done) break;
            @(negedge clk);
        end
        chk(bad == 0, "R1", {name, " ready low while busy"}, bad, 0);
        chk(result == 2'(res), req, {name, " result"}, result, res);
        chk(exp_q.size() == 0, req, {name, " commands left unissued"}, exp_q.size(), 0);
        if (res == 2 || op == 3)
            chk(cyc == 1, req, {name, " refusal latency"}, cyc, 1);
        @(negedge clk);
        chk(!done && req_ready, "R1", {name, " done is one pulse"}, {done, req_ready}, 1);
        exp_q.delete();
        st_q.delete();
        err_opc = -1;
    endtask

    initial begin
        for (int i = 0; i < PAGE; i++) txmem[i] = 8'(i) ^ 8'h5A;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !cmd_valid, "R1", "reset state",
            {req_ready, done, cmd_valid}, 3'b100);

        st_q = '{1, 1, 0};
        run("read single", 0, 'h012345, 1, 0, 8, "R2");
        st_q = '{0};
        run("read quad", 0, 'h000777, 1, 1, 8, "R2");
        st_q = '{'h0C};
        run("read ignores fail bits", 0, 'h000010, 1, 0, 8, "R6");
        st_q = '{0};
        run("read while protected", 0, 'h000020, 0, 0, 8, "R7");
        st_q = '{1, 0};
        run("program quad", 1, 'h00ABCD, 1, 1, 8, "R3");
        st_q = '{'h08};
        run("program fail", 1, 'h000100, 1, 0, 8, "R6");
        st_q = '{'h04};
        run("program ignores erase bit", 1, 'h000101, 1, 0, 8, "R6");
        st_q = '{1, 'h04};
        run("erase fail aligned", 2, 'h0001FF, 1, 0, 8, "R4");
        st_q = '{'h08};
        run("erase ignores program bit", 2, 'h000040, 1, 0, 8, "R6");
        run("program protected", 1, 'h000200, 0, 0, 8, "R7");
        run("erase protected", 2, 'h000200, 0, 0, 8, "R7");
        st_q = '{1, 1, 1, 1, 1};
        run("poll timeout", 2, 'h000080, 1, 0, 3, "R8");
        st_q = '{1, 1, 0};
        run("poll at limit edge", 2, 'h0000C0, 1, 0, 3, "R8");
        st_q = '{1, 1};
        run("poll limit zero", 0, 'h000005, 1, 0, 0, "R8");
        err_opc = 'h32;
        run("engine error on load", 1, 'h000300, 1, 1, 8, "R9");
        run("reserved op", 3, 'h000001, 1, 0, 8, "R10");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule